// File: doc/BRIEF.md
# Retimer Channel Override Controller

This block owns the per-lane control registers of a serial retimer lane and turns them, together with a few status inputs from the analog and clock-recovery parts of the lane, into three decisions. The first is whether the lane is powered. The second is which candidate source the output driver carries. The third is which power-of-two ratio divides the oscillator clock. Each decision normally follows hardware: the detect flag, the lock flag and an automatic divider choice. Each one can be taken over by software through its own override bit.

Software reaches the registers through a plain synchronous port with an 8-bit address and 8-bit data. A write lands on the rising clock edge. Read data is a combinational view of the register at the presented address. The candidate sources are retimed data, raw data, a PRBS bit, the I and Q clock phases and a slow reference clock. They arrive as single-bit inputs that the block only selects among. No source is an interface with flow control, so the block has no valid/ready handshake and no back-pressure. The divided clock is a square wave produced on the block clock.

Top module: `retimer_override_ctrl`

## Requirements
- R1: After reset every register reads 0x00. That value means automatic control for lane power, output source and divider.
- R2: A write to address 0x09, 0x14, 0x18 or 0x1E stores the full byte, and a later read of that address returns it. A write to any other address changes no stored register. A read of any other address returns 0x00.
- R3: Bits [7:6] of register 0x14 set lane power. With 00, lane_enable follows sig_detect. With 10, lane_enable is 1 whatever sig_detect is. With bit 6 set (01 or 11), lane_enable is 0.
- R4: While lane_enable is 0, lane_out is 0 whatever source is chosen.
- R5: While bit 5 of register 0x09 is 0 and the lane is enabled, lane_out carries src_retimed when cdr_locked is 1 and 0 when cdr_locked is 0.
- R6: While bit 5 of register 0x09 is 1 and the lane is enabled, bits [7:5] of register 0x1E choose lane_out. Code 0 is retimed, 1 is raw, 2 is PRBS, 3 is the I clock, 4 is the Q clock and 5 is the reference clock. Codes 6 and 7 give 0. The reference clock follows with or without detect or lock.
- R7: While bit 2 of register 0x09 is 1, bits [6:4] of register 0x18 give the divider code. While it is 0, auto_div_code gives the code.
- R8: Divider codes 0, 1, 2, 3 and 4 select ratios 1, 2, 4, 8 and 16. Codes 5, 6 and 7 select ratio 16.
- R9: div_clk is 0 after reset. It toggles after each run of N clock edges, where N is the selected ratio. On an edge where the selected ratio differs from the one at the previous edge, div_clk holds its level and the run count restarts from zero, so no high or low phase is cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | 8 | Register address for writes and reads |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| sig_detect | input | 1 | Input-signal detect flag from the lane |
| cdr_locked | input | 1 | Clock recovery lock flag |
| auto_div_code | input | 3 | Hardware-chosen divider code |
| src_retimed | input | 1 | Retimed data bit |
| src_raw | input | 1 | Raw (unretimed) data bit |
| src_prbs | input | 1 | PRBS generator bit |
| src_iclk | input | 1 | Oscillator in-phase clock |
| src_qclk | input | 1 | Oscillator quadrature clock |
| src_refclk | input | 1 | Slow free-running reference clock |
| lane_enable | output | 1 | Lane power enable |
| lane_out | output | 1 | Bit presented to the output driver |
| div_clk | output | 1 | Divided clock |

## Verification
The hardest situation to reach from the ports is a change of divider ratio in the middle of a div_clk phase. A wrong restart there shows up only as a phase one or more edges too short. It needs an override write or an auto_div_code step to land at a chosen count within the current run. The bench reaches it by changing the code at several offsets, both while an override is held and through the automatic input. It moves from long ratios to short ones and from short to long, and also flips the override bit alone. Output selection under a forced-on lane with no detect and no lock is reached by writing the force code first and then walking every source code while the detect and lock inputs are held low and then toggled.

// File: rtl/rtovr_pkg.sv
package rtovr_pkg;

  // Field positions inside the control registers. Software decodes these.
  localparam int MUX_OVR_BIT   = 5;  // in the control register (0x09)
  localparam int DIV_OVR_BIT   = 2;  // in the control register (0x09)
  localparam int FORCE_ON_BIT  = 7;  // in the detect register (0x14)
  localparam int FORCE_OFF_BIT = 6;  // in the detect register (0x14)
  localparam int DIVSEL_LSB    = 4;  // divider code field [6:4] in 0x18
  localparam int SRCSEL_LSB    = 5;  // source code field [7:5] in 0x1E
  localparam int SEL_W         = 3;

  // Register slots inside the bank.
  localparam int SLOT_CTRL = 0;
  localparam int SLOT_DET  = 1;
  localparam int SLOT_DIV  = 2;
  localparam int SLOT_SRC  = 3;
  localparam int NUM_SLOTS = 4;

  typedef enum logic [SEL_W-1:0] {
    SRC_RETIMED = 3'd0,
    SRC_RAW     = 3'd1,
    SRC_PRBS    = 3'd2,
    SRC_ICLK    = 3'd3,
    SRC_QCLK    = 3'd4,
    SRC_REFCLK  = 3'd5,
    SRC_QUIET6  = 3'd6,
    SRC_QUIET7  = 3'd7
  } src_sel_e;

  typedef struct packed {
    logic              mux_ovr;
    logic              div_ovr;
    logic              force_on;
    logic              force_off;
    logic [SEL_W-1:0]  src_code;
    logic [SEL_W-1:0]  div_code;
  } ovr_ctrl_t;

endpackage

// File: rtl/rtovr_regs.sv
module rtovr_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NREG   = 4,
  parameter logic [NREG*ADDR_W-1:0] ADDR_MAP = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rdata,
  output logic                   any_hit,
  output logic [NREG*DATA_W-1:0] regs_flat
);

  logic [NREG-1:0] hit;

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    logic [DATA_W-1:0] slot_q;

    assign hit[i] = (addr == ADDR_MAP[i*ADDR_W +: ADDR_W]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (wr_en && hit[i]) begin
        slot_q <= wdata;
      end
    end

    assign regs_flat[i*DATA_W +: DATA_W] = slot_q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) begin
        rdata = rdata | regs_flat[i*DATA_W +: DATA_W];
      end
    end
  end

  assign any_hit = |hit;

endmodule

// File: rtl/rtovr_lane_sel.sv
module rtovr_lane_sel
  import rtovr_pkg::*;
(
  input  ovr_ctrl_t ctrl,
  input  logic      sig_detect,
  input  logic      cdr_locked,
  input  logic      src_retimed,
  input  logic      src_raw,
  input  logic      src_prbs,
  input  logic      src_iclk,
  input  logic      src_qclk,
  input  logic      src_refclk,
  output logic      lane_enable,
  output logic      lane_out
);

  logic picked;

  // Power: a set force-off bit wins over force-on, which wins over detect.
  always_comb begin
    if (ctrl.force_off) begin
      lane_enable = 1'b0;
    end else if (ctrl.force_on) begin
      lane_enable = 1'b1;
    end else begin
      lane_enable = sig_detect;
    end
  end

  always_comb begin
    if (ctrl.mux_ovr) begin
      case (src_sel_e'(ctrl.src_code))
        SRC_RETIMED: picked = src_retimed;
        SRC_RAW:     picked = src_raw;
        SRC_PRBS:    picked = src_prbs;
        SRC_ICLK:    picked = src_iclk;
        SRC_QCLK:    picked = src_qclk;
        SRC_REFCLK:  picked = src_refclk;
        default:     picked = 1'b0;
      endcase
    end else begin
      picked = cdr_locked & src_retimed;
    end
  end

  assign lane_out = lane_enable & picked;

endmodule

// File: rtl/rtovr_clk_div.sv
module rtovr_clk_div #(
  parameter int CODE_W  = 3,
  parameter int MAX_LOG = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CODE_W-1:0]   code,
  output logic [MAX_LOG:0]    ratio,
  output logic                div_clk
);

  localparam int RATIO_W = MAX_LOG + 1;
  localparam int CNT_W   = (MAX_LOG > 0) ? MAX_LOG : 1;

  logic [RATIO_W-1:0] ratio_q;
  logic [CNT_W-1:0]   run_cnt;
  logic               last_edge;
  logic               changed;

  // Codes beyond the largest ratio saturate to it.
  always_comb begin
    ratio = '0;
    if (code >= CODE_W'(MAX_LOG)) begin
      ratio[MAX_LOG] = 1'b1;
    end else begin
      ratio[code] = 1'b1;
    end
  end

  assign changed   = (ratio != ratio_q);
  assign last_edge = ({1'b0, run_cnt} == (ratio - RATIO_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= RATIO_W'(1);
      run_cnt <= '0;
      div_clk <= 1'b0;
    end else begin
      ratio_q <= ratio;
      if (changed) begin
        run_cnt <= '0;
      end else if (last_edge) begin
        run_cnt <= '0;
        div_clk <= ~div_clk;
      end else begin
        run_cnt <= run_cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/retimer_override_ctrl.sv
module retimer_override_ctrl
  import rtovr_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'h09,
  parameter logic [ADDR_W-1:0] DET_ADDR    = 8'h14,
  parameter logic [ADDR_W-1:0] DIV_ADDR    = 8'h18,
  parameter logic [ADDR_W-1:0] SRC_ADDR    = 8'h1E,
  parameter int                DIV_CODE_W  = 3,
  parameter int                MAX_DIV_LOG = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr_en,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic                  sig_detect,
  input  logic                  cdr_locked,
  input  logic [DIV_CODE_W-1:0] auto_div_code,
  input  logic                  src_retimed,
  input  logic                  src_raw,
  input  logic                  src_prbs,
  input  logic                  src_iclk,
  input  logic                  src_qclk,
  input  logic                  src_refclk,
  output logic                  lane_enable,
  output logic                  lane_out,
  output logic                  div_clk
);

  localparam logic [NUM_SLOTS*ADDR_W-1:0] ADDR_MAP =
    {SRC_ADDR, DIV_ADDR, DET_ADDR, CTRL_ADDR};

  logic [NUM_SLOTS*DATA_W-1:0] regs_flat;
  logic [DATA_W-1:0]           ctrl_reg, det_reg, div_reg, src_reg;
  logic                        reg_hit;
  ovr_ctrl_t                   ctrl;
  logic [DIV_CODE_W-1:0]       div_code_sel;
  logic [MAX_DIV_LOG:0]        ratio;

  // Plain views of the decoded controls, also used by the checker.
  logic                        mux_ovr, div_ovr, force_on, force_off;
  logic [SEL_W-1:0]            src_code;
  logic                        unused_bits;

  rtovr_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NREG     (NUM_SLOTS),
    .ADDR_MAP (ADDR_MAP)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .any_hit   (reg_hit),
    .regs_flat (regs_flat)
  );

  assign ctrl_reg = regs_flat[SLOT_CTRL*DATA_W +: DATA_W];
  assign det_reg  = regs_flat[SLOT_DET*DATA_W  +: DATA_W];
  assign div_reg  = regs_flat[SLOT_DIV*DATA_W  +: DATA_W];
  assign src_reg  = regs_flat[SLOT_SRC*DATA_W  +: DATA_W];

  always_comb begin
    ctrl.mux_ovr   = ctrl_reg[MUX_OVR_BIT];
    ctrl.div_ovr   = ctrl_reg[DIV_OVR_BIT];
    ctrl.force_on  = det_reg[FORCE_ON_BIT];
    ctrl.force_off = det_reg[FORCE_OFF_BIT];
    ctrl.src_code  = src_reg[SRCSEL_LSB +: SEL_W];
    ctrl.div_code  = div_reg[DIVSEL_LSB +: SEL_W];
  end

  assign mux_ovr   = ctrl.mux_ovr;
  assign div_ovr   = ctrl.div_ovr;
  assign force_on  = ctrl.force_on;
  assign force_off = ctrl.force_off;
  assign src_code  = ctrl.src_code;
  assign unused_bits = ^{ctrl_reg, det_reg, div_reg, src_reg, reg_hit, ratio};

  assign div_code_sel = ctrl.div_ovr ? DIV_CODE_W'(ctrl.div_code) : auto_div_code;

  rtovr_lane_sel u_lane (
    .ctrl        (ctrl),
    .sig_detect  (sig_detect),
    .cdr_locked  (cdr_locked),
    .src_retimed (src_retimed),
    .src_raw     (src_raw),
    .src_prbs    (src_prbs),
    .src_iclk    (src_iclk),
    .src_qclk    (src_qclk),
    .src_refclk  (src_refclk),
    .lane_enable (lane_enable),
    .lane_out    (lane_out)
  );

  rtovr_clk_div #(
    .CODE_W  (DIV_CODE_W),
    .MAX_LOG (MAX_DIV_LOG)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .code    (div_code_sel),
    .ratio   (ratio),
    .div_clk (div_clk)
  );

endmodule

// File: rtl/rtovr_checker.sv
module rtovr_checker #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 8,
  parameter int MAX_LOG = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr_en,
  input logic               reg_hit,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic               force_on,
  input logic               force_off,
  input logic               mux_ovr,
  input logic [2:0]         src_code,
  input logic               src_refclk,
  input logic               lane_enable,
  input logic               lane_out,
  input logic [MAX_LOG:0]   ratio,
  input logic               div_clk
);

  logic [MAX_LOG:0] prev_ratio;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_ratio <= (MAX_LOG+1)'(1);
    else        prev_ratio <= ratio;
  end

  // R2: a stored byte is visible on the next cycle at the same address
  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_hit) |=>
      ((reg_addr != $past(reg_addr)) || (reg_rdata == $past(reg_wdata))));

  // R3: force-off wins, force-on holds the lane up
  assert_force_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |-> !lane_enable);

  assert_force_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (force_on && !force_off) |-> lane_enable);

  // R4: muted driver
  assert_muted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_enable |-> !lane_out);

  // R6: reference clock always selectable, quiet codes stay low
  assert_refclk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_enable && mux_ovr && src_code == 3'd5) |-> (lane_out == src_refclk));

  assert_quiet_codes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_ovr && src_code[2:1] == 2'b11) |-> !lane_out);

  // R8: exactly one ratio selected
  assert_ratio_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ratio) == 1);

  // R9: no toggle on the edge where the ratio changes
  assert_hold_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio != prev_ratio) |=> $stable(div_clk));

endmodule

bind retimer_override_ctrl rtovr_checker #(
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .MAX_LOG (MAX_DIV_LOG)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_hit     (reg_hit),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .force_on    (force_on),
  .force_off   (force_off),
  .mux_ovr     (mux_ovr),
  .src_code    (src_code),
  .src_refclk  (src_refclk),
  .lane_enable (lane_enable),
  .lane_out    (lane_out),
  .ratio       (ratio),
  .div_clk     (div_clk)
);

// File: tb/test_retimer_override_ctrl.sv
`timescale 1ns/1ps
module test_retimer_override_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sig_detect = 1'b0;
  logic       cdr_locked = 1'b0;
  logic [2:0] auto_div_code = 3'd0;
  logic       src_retimed = 1'b0, src_raw = 1'b0, src_prbs = 1'b0;
  logic       src_iclk = 1'b0, src_qclk = 1'b0, src_refclk = 1'b0;
  logic       lane_enable, lane_out, div_clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #5 clk = ~clk;

  retimer_override_ctrl i_retimer_override_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sig_detect(sig_detect),
    .cdr_locked(cdr_locked), .auto_div_code(auto_div_code),
    .src_retimed(src_retimed), .src_raw(src_raw), .src_prbs(src_prbs),
    .src_iclk(src_iclk), .src_qclk(src_qclk), .src_refclk(src_refclk),
    .lane_enable(lane_enable), .lane_out(lane_out), .div_clk(div_clk)
  );

  // Source activity: a free-running LFSR drives the data-like sources.
  logic [15:0] lfsr = 16'hACE1;
  int          slow = 0;
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    src_retimed = lfsr[0];
    src_raw     = lfsr[3];
    src_prbs    = lfsr[7];
    src_iclk    = ~src_iclk;
    src_qclk    = src_iclk ^ lfsr[9];
    slow        = slow + 1;
    src_refclk  = slow[3];
  end

  // ---------------- reference model ----------------
  logic [7:0] m_ctl = 8'h00, m_det = 8'h00, m_div = 8'h00, m_src = 8'h00;
  int         m_cnt = 0, m_prev = 1;
  logic       m_lvl = 1'b0;

  function automatic int m_code();
    return m_ctl[2] ? int'(m_div[6:4]) : int'(auto_div_code);
  endfunction

  function automatic int m_ratio();
    int c;
    c = m_code();
    return (c > 4) ? 16 : (1 << c);
  endfunction

  always @(posedge clk) begin
    int r;
    if (!rst_n) begin
      m_ctl = 8'h00; m_det = 8'h00; m_div = 8'h00; m_src = 8'h00;
      m_cnt = 0; m_prev = 1; m_lvl = 1'b0;
    end else begin
      r = m_ratio();
      if (r != m_prev) m_cnt = 0;
      else if (m_cnt == r - 1) begin m_cnt = 0; m_lvl = ~m_lvl; end
      else m_cnt = m_cnt + 1;
      m_prev = r;
      if (reg_wr_en) begin
        case (reg_addr)
          8'h09: m_ctl = reg_wdata;
          8'h14: m_det = reg_wdata;
          8'h18: m_div = reg_wdata;
          8'h1E: m_src = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic exp_enable();
    if (m_det[6]) return 1'b0;
    if (m_det[7]) return 1'b1;
    return sig_detect;
  endfunction

  function automatic logic exp_out();
    if (!exp_enable()) return 1'b0;
    if (!m_ctl[5]) return cdr_locked & src_retimed;
    case (m_src[7:5])
      3'd0: return src_retimed;
      3'd1: return src_raw;
      3'd2: return src_prbs;
      3'd3: return src_iclk;
      3'd4: return src_qclk;
      3'd5: return src_refclk;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] exp_rdata();
    case (reg_addr)
      8'h09: return m_ctl;
      8'h14: return m_det;
      8'h18: return m_div;
      8'h1E: return m_src;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: got %h expected %h", tag, $time, got, exp);
    end
  endtask

  // Compare every cycle, 3 ns after the edge, before the inputs move.
  always @(posedge clk) begin
    string tag_out, tag_div;
    #3;
    chk("R2 reg_rdata", reg_rdata, exp_rdata());
    chk("R3 lane_enable", {7'd0, lane_enable}, {7'd0, exp_enable()});
    if (!exp_enable())  tag_out = "R4 lane_out";
    else if (m_ctl[5])  tag_out = "R6 lane_out";
    else                tag_out = "R5 lane_out";
    chk(tag_out, {7'd0, lane_out}, {7'd0, exp_out()});
    if (m_ctl[2])       tag_div = (m_div[6:4] > 3'd4) ? "R8 div_clk" : "R7 div_clk";
    else                tag_div = "R9 div_clk";
    chk(tag_div, {7'd0, div_clk}, {7'd0, m_lvl});
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  initial begin
    logic [7:0] addrs [5];
    addrs = '{8'h09, 8'h14, 8'h18, 8'h1E, 8'h33};
    idle(4);
    rst_n = 1'b1;
    // R1: reset values
    foreach (addrs[i]) begin
      @(negedge clk);
      reg_addr = addrs[i];
      #1 chk("R1 reset read", reg_rdata, 8'h00);
    end
    chk("R1 lane_enable idle", {7'd0, lane_enable}, 8'h00);

    // R2: readback and unmapped addresses
    wr(8'h18, 8'h8B); idle(2);
    wr(8'h1E, 8'h1F); idle(2);
    wr(8'h55, 8'hAA); idle(2);
    reg_addr = 8'h55; idle(2);
    wr(8'h14, 8'h3D); idle(2);
    wr(8'h09, 8'hDB); idle(4);
    wr(8'h09, 8'h00); wr(8'h14, 8'h00); wr(8'h18, 8'h00); wr(8'h1E, 8'h00);

    // R3, R5: automatic detect and lock
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      sig_detect = k[1];
      cdr_locked = k[2];
    end
    sig_detect = 1'b0; cdr_locked = 1'b0;
    wr(8'h14, 8'h80); idle(6);
    cdr_locked = 1'b1; idle(6);
    wr(8'h14, 8'h40); sig_detect = 1'b1; idle(6);
    wr(8'h14, 8'hC0); idle(6);
    wr(8'h14, 8'h00); idle(6);
    sig_detect = 1'b0; idle(4);

    // R6: every source code, forced lane with no detect or lock first
    wr(8'h14, 8'h80);
    wr(8'h09, 8'h20);
    cdr_locked = 1'b0;
    for (int s = 0; s < 8; s++) begin
      wr(8'h1E, 8'((s << 5) | 8'h0B));
      idle(20);
    end
    wr(8'h14, 8'h00);
    for (int s = 0; s < 8; s++) begin
      wr(8'h1E, 8'(s << 5));
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        sig_detect = k[2] | k[0];
        cdr_locked = k[1];
      end
    end
    wr(8'h09, 8'h00);
    sig_detect = 1'b1; cdr_locked = 1'b1; idle(10);

    // R8, R9: automatic divider codes, changed at differing offsets
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      auto_div_code = 3'(c);
      idle(40 + 3 * c);
    end
    auto_div_code = 3'd1; idle(7);
    auto_div_code = 3'd4; idle(11);
    auto_div_code = 3'd0; idle(5);
    auto_div_code = 3'd3; idle(3);
    auto_div_code = 3'd2; idle(30);

    // R7, R8: override codes, then override bit alone
    wr(8'h18, 8'h40);
    wr(8'h09, 8'h04); idle(45);
    for (int c = 0; c < 8; c++) begin
      wr(8'h18, 8'(c << 4));
      idle(37 + 2 * c);
    end
    wr(8'h18, 8'h30); idle(13);
    wr(8'h18, 8'h10); idle(9);
    wr(8'h09, 8'h00); idle(21);
    wr(8'h09, 8'h04); idle(21);
    wr(8'h18, 8'h70); idle(50);

    // Reset in the middle of activity returns everything to defaults (R1)
    @(negedge clk);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    reg_addr = 8'h09;
    #1 chk("R1 read after reset", reg_rdata, 8'h00);
    idle(10);
    finish_run();
  end

endmodule